// File: doc/BRIEF.md
# Dual-Counter Performance Monitor

The block counts hardware events with two 32-bit counters that share one control register. Each counter picks one of a set of per-cycle event strobes through its own select field, and counts it in any cycle where the current execution context (user, supervisor or hypervisor) has its enable bit set in the control register. The context enables and the interrupt enable apply to both counters at once. Neither counter can be stopped on its own, so an idle counter keeps counting whatever its select field names.

Software sets up a sampling period by preloading a counter with the two's complement of the desired event count. When a counter wraps from all ones to zero, its own sticky status bit is set. The interrupt line is raised while any status bit is set and interrupts are enabled. This lets the handler see which counter wrapped, including one nobody is using. Both counters sit in one 64-bit register. A per-half write enable updates one counter without disturbing the other.

Top module: `perf_pair_mon`

## Requirements
- R1: After reset both counters, the control register and both status bits read 0, and `irq` is low.
- R2: A counter goes up by exactly one after each clock edge where its selected strobe is high and the enable bit for the current `ctxMode` is set. The encodings are 0 = user (control bit 0), 1 = supervisor (bit 1) and 2 = hypervisor (bit 2).
- R3: With `ctxMode` = 3, or with the enable bit of the current context clear, neither counter changes. With all three enable bits clear, no counting happens in any context.
- R4: The enables are shared. A counter nobody uses still counts its selected event and can still set its own status bit.
- R5: Register 1 holds counter 0 in bits 63:32 and counter 1 in bits 31:0. A write to it loads counter i only when `regHalfEn[i]` is set, and the other counter keeps its value.
- R6: When the port writes a counter in the same cycle that its event would increment it, the written value wins.
- R7: A counter that wraps from 0xFFFFFFFF to 0 sets status bit i (register 2, bit i, for counter i) at that same edge, and then counts on from 0.
- R8: Status bits stay set until a write to register 2 with a 1 in bit i clears bit i. If a wrap and a clear of the same bit fall in one cycle, the bit stays set.
- R9: `irq` is high exactly when some status bit is set and the interrupt enable (control bit 3) is set. Status is still recorded while the interrupt enable is clear.
- R10: A counter preloaded with 2^32 − N sets its status bit on the N-th counted event and not before.
- R11: Register 0 reads back the control value written to it. The select field for counter 0 is bits 19:16 and the select field for counter 1 is bits 11:8. Each field is an index into `evtStrobe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evtStrobe | input | 16 | Per-cycle event strobes |
| ctxMode | input | 2 | Current context: 0 user, 1 supervisor, 2 hypervisor, 3 none |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 control, 1 counters, 2 status |
| regWrData | input | 64 | Write data |
| regHalfEn | input | 2 | Per-counter write enable for register 1 |
| regRdData | output | 64 | Read data for `regAddr` |
| countHi | output | 32 | Counter 0 value |
| countLo | output | 32 | Counter 1 value |
| ovfStatus | output | 2 | Sticky wrap status, bit i for counter i |
| irq | output | 1 | Overflow interrupt |

## Verification
Counting is driven from a table that steps through every context code against enable sets that include and exclude it. It mixes strobes on the selected lines, on both selected lines together, on an unselected line and on all lines at once. This separates a wrong context decode from a wrong event select and from counters that are wrongly tied together. Directed cases then preload counters near the wrap point. They show that the flag appears on the exact event that wraps, on the idle counter as well, and that it survives a clear in the same cycle. They also cover half-register writes, and a write that collides with an increment.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int CNT_W    = 32;
  localparam int NUM_CNT  = 2;
  localparam int NUM_EVT  = 16;
  localparam int SEL_W    = $clog2(NUM_EVT);
  localparam int CTRL_W   = 32;
  localparam int ADDR_W   = 2;
  localparam int DATA_W   = CNT_W * NUM_CNT;

  // control register bit positions
  localparam int USR_BIT     = 0;
  localparam int SUP_BIT     = 1;
  localparam int HYP_BIT     = 2;
  localparam int IRQ_BIT     = 3;
  localparam int SEL_LO_LSB  = 8;
  localparam int SEL_HI_LSB  = 16;

  // register addresses
  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STS  = 2'd2;

  typedef enum logic [1:0] {
    CTX_USER = 2'd0,
    CTX_SUP  = 2'd1,
    CTX_HYP  = 2'd2,
    CTX_NONE = 2'd3
  } ctx_e;

  typedef struct packed {
    logic [NUM_CNT-1:0] cntWr;
    logic [NUM_CNT-1:0] cntInc;
    logic [NUM_CNT-1:0] stsClr;
  } pmu_strobe_t;
endpackage

// File: rtl/pmu_ctrl.sv
module pmu_ctrl
  import pmu_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_EVT-1:0]  evtStrobe,
  input  logic [1:0]          ctxMode,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [CTRL_W-1:0]   regWrData,
  input  logic [NUM_CNT-1:0]  regHalfEn,
  output logic [CTRL_W-1:0]   ctrlQ,
  output logic                irqEn,
  output pmu_strobe_t         strb
);
  logic ctxOk;
  logic [SEL_W-1:0] selOf [NUM_CNT];

  always_ff @(posedge clk) begin
    if (!rst_n) ctrlQ <= '0;
    else if (regWrEn && regAddr == ADDR_CTRL) ctrlQ <= regWrData;
  end

  always_comb begin
    unique case (ctx_e'(ctxMode))
      CTX_USER: ctxOk = ctrlQ[USR_BIT];
      CTX_SUP:  ctxOk = ctrlQ[SUP_BIT];
      CTX_HYP:  ctxOk = ctrlQ[HYP_BIT];
      default:  ctxOk = 1'b0;
    endcase
  end

  assign irqEn    = ctrlQ[IRQ_BIT];
  assign selOf[0] = ctrlQ[SEL_HI_LSB +: SEL_W];
  assign selOf[1] = ctrlQ[SEL_LO_LSB +: SEL_W];

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_strb
    assign strb.cntInc[i] = ctxOk && evtStrobe[selOf[i]];
    assign strb.cntWr[i]  = regWrEn && regAddr == ADDR_CNT && regHalfEn[i];
    assign strb.stsClr[i] = regWrEn && regAddr == ADDR_STS && regWrData[i];
  end
endmodule

// File: rtl/pmu_datapath.sv
module pmu_datapath
  import pmu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  pmu_strobe_t        strb,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [CNT_W-1:0]   cntHi,
  output logic [CNT_W-1:0]   cntLo,
  output logic [NUM_CNT-1:0] ovfQ
);
  logic [CNT_W-1:0] cntQ [NUM_CNT];

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    // counter 0 lives in the upper half of the shared register
    localparam int LSB = (NUM_CNT - 1 - i) * CNT_W;
    logic wrapNow;
    assign wrapNow = strb.cntInc[i] && !strb.cntWr[i] && (cntQ[i] == '1);

    always_ff @(posedge clk) begin
      if (!rst_n) cntQ[i] <= '0;
      else if (strb.cntWr[i]) cntQ[i] <= regWrData[LSB +: CNT_W];
      else if (strb.cntInc[i]) cntQ[i] <= cntQ[i] + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) ovfQ[i] <= 1'b0;
      else if (wrapNow) ovfQ[i] <= 1'b1;
      else if (strb.stsClr[i]) ovfQ[i] <= 1'b0;
    end
  end

  assign cntHi = cntQ[0];
  assign cntLo = cntQ[1];
endmodule

// File: rtl/perf_pair_mon.sv
module perf_pair_mon
  import pmu_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_EVT-1:0]  evtStrobe,
  input  logic [1:0]          ctxMode,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  input  logic [NUM_CNT-1:0]  regHalfEn,
  output logic [DATA_W-1:0]   regRdData,
  output logic [CNT_W-1:0]    countHi,
  output logic [CNT_W-1:0]    countLo,
  output logic [NUM_CNT-1:0]  ovfStatus,
  output logic                irq
);
  pmu_strobe_t      strb;
  logic [CTRL_W-1:0] ctrlQ;
  logic             irqEn;

  pmu_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .evtStrobe(evtStrobe), .ctxMode(ctxMode),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData[CTRL_W-1:0]),
    .regHalfEn(regHalfEn), .ctrlQ(ctrlQ), .irqEn(irqEn), .strb(strb)
  );

  pmu_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .regWrData(regWrData),
    .cntHi(countHi), .cntLo(countLo), .ovfQ(ovfStatus)
  );

  assign irq = irqEn && (|ovfStatus);

  always_comb begin
    unique case (regAddr)
      ADDR_CTRL: regRdData = {{(DATA_W-CTRL_W){1'b0}}, ctrlQ};
      ADDR_CNT:  regRdData = {countHi, countLo};
      ADDR_STS:  regRdData = {{(DATA_W-NUM_CNT){1'b0}}, ovfStatus};
      default:   regRdData = '0;
    endcase
  end
endmodule

// File: rtl/pmu_checker.sv
module pmu_checker
  import pmu_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input pmu_strobe_t        strb,
  input logic [DATA_W-1:0]  regWrData,
  input logic [CNT_W-1:0]   countHi,
  input logic [CNT_W-1:0]   countLo,
  input logic [NUM_CNT-1:0] ovfStatus,
  input logic               irqEn,
  input logic               irq
);
  a_r2_step_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.cntInc[0] && !strb.cntWr[0]) |=> countHi == $past(countHi) + CNT_W'(1));
  a_r2_step_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.cntInc[1] && !strb.cntWr[1]) |=> countLo == $past(countLo) + CNT_W'(1));
  a_r3_hold_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.cntInc[0] && !strb.cntWr[0]) |=> $stable(countHi));
  a_r3_hold_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb.cntInc[1] && !strb.cntWr[1]) |=> $stable(countLo));
  a_r6_write_wins_hi: assert property (@(posedge clk) disable iff (!rst_n)
    strb.cntWr[0] |=> countHi == $past(regWrData[DATA_W-1:CNT_W]));
  a_r6_write_wins_lo: assert property (@(posedge clk) disable iff (!rst_n)
    strb.cntWr[1] |=> countLo == $past(regWrData[CNT_W-1:0]));
  a_r7_wrap_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (countHi == '1 && strb.cntInc[0] && !strb.cntWr[0]) |=> ovfStatus[0] && countHi == '0);
  a_r7_wrap_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (countLo == '1 && strb.cntInc[1] && !strb.cntWr[1]) |=> ovfStatus[1] && countLo == '0);
  a_r8_sticky_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (ovfStatus[0] && !strb.stsClr[0]) |=> ovfStatus[0]);
  a_r8_sticky_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (ovfStatus[1] && !strb.stsClr[1]) |=> ovfStatus[1]);
  a_r9_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !irqEn |-> !irq);
  a_r9_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (irqEn && ovfStatus != '0) |-> irq);
endmodule

bind perf_pair_mon pmu_checker u_chk (
  .clk(clk), .rst_n(rst_n), .strb(strb), .regWrData(regWrData),
  .countHi(countHi), .countLo(countLo), .ovfStatus(ovfStatus),
  .irqEn(irqEn), .irq(irq)
);

// File: tb/perf_pair_mon_bench.sv
`timescale 1ns/100ps
module perf_pair_mon_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evtStrobe = '0;
  logic [1:0]  ctxMode = 2'd0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [63:0] regWrData = '0;
  logic [1:0]  regHalfEn = '0;
  logic [63:0] regRdData;
  logic [31:0] countHi, countLo;
  logic [1:0]  ovfStatus;
  logic        irq;

  int tests = 0;
  int fails = 0;

  perf_pair_mon u_perf_pair_mon (
    .clk(clk), .rst_n(rst_n), .evtStrobe(evtStrobe), .ctxMode(ctxMode),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regHalfEn(regHalfEn), .regRdData(regRdData), .countHi(countHi),
    .countLo(countLo), .ovfStatus(ovfStatus), .irq(irq)
  );

  always #2.5 clk = ~clk;

  // control words: bit0 user, bit1 sup, bit2 hyp, bit3 irq, [19:16] sel0, [11:8] sel1
  localparam logic [63:0] SEL35 = 64'h0003_0500;

  // vector: [19:18] ctxMode, [17:2] evtStrobe, [1] counter0 step, [0] counter1 step
  // run with user+supervisor enabled, counter0 on line 3, counter1 on line 5
  localparam logic [19:0] VEC [8] = '{
    {2'd0, 16'h0008, 1'b1, 1'b0},
    {2'd0, 16'h0020, 1'b0, 1'b1},
    {2'd1, 16'h0028, 1'b1, 1'b1},
    {2'd2, 16'h0028, 1'b0, 1'b0},
    {2'd3, 16'h0028, 1'b0, 1'b0},
    {2'd0, 16'h0010, 1'b0, 1'b0},
    {2'd1, 16'hFFFF, 1'b1, 1'b1},
    {2'd0, 16'h0000, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [63:0] d, input logic [1:0] he);
    regWrEn = 1'b1; regAddr = a; regWrData = d; regHalfEn = he;
    @(negedge clk);
    regWrEn = 1'b0; regHalfEn = '0;
  endtask

  task automatic pulse(input logic [1:0] ctx, input logic [15:0] ev);
    ctxMode = ctx; evtStrobe = ev;
    @(negedge clk);
    evtStrobe = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [63:0] v);
    regAddr = a; #0.5; v = regRdData;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [63:0] v;
    logic [31:0] expHi, expLo;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 countHi", {32'b0, countHi}, 64'd0);
    chk("R1 countLo", {32'b0, countLo}, 64'd0);
    chk("R1 status", {62'b0, ovfStatus}, 64'd0);
    chk("R1 irq", {63'b0, irq}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, v); chk("R1 control", v, 64'd0);

    // R11 control readback
    wr(2'd0, SEL35 | 64'h3, 2'b00);
    rd(2'd0, v); chk("R11 control readback", v, SEL35 | 64'h3);

    // table-driven counting: R2 R3 R4
    wr(2'd1, 64'd0, 2'b11);
    expHi = 0; expLo = 0;
    for (int k = 0; k < 8; k++) begin
      pulse(VEC[k][19:18], VEC[k][17:2]);
      expHi += {31'b0, VEC[k][1]};
      expLo += {31'b0, VEC[k][0]};
      chk($sformatf("R2 vec%0d counter0", k), {32'b0, countHi}, {32'b0, expHi});
      chk($sformatf("R4 vec%0d counter1", k), {32'b0, countLo}, {32'b0, expLo});
    end

    // R2 hypervisor-only enable counts in context 2, not in context 0
    wr(2'd0, SEL35 | 64'h4, 2'b00);
    pulse(2'd2, 16'h0028);
    chk("R2 hyp ctx counts", {countHi, countLo}, {expHi + 32'd1, expLo + 32'd1});
    pulse(2'd0, 16'h0028);
    chk("R3 user ctx disabled", {countHi, countLo}, {expHi + 32'd1, expLo + 32'd1});

    // R3 all enables clear: no context counts
    wr(2'd0, SEL35, 2'b00);
    wr(2'd1, 64'h0000_0010_0000_0020, 2'b11);
    pulse(2'd0, 16'hFFFF); pulse(2'd1, 16'hFFFF); pulse(2'd2, 16'hFFFF);
    chk("R3 all enables clear", {countHi, countLo}, 64'h0000_0010_0000_0020);

    // R5 half write keeps the other counter
    wr(2'd1, 64'hAAAA_0001_BBBB_0002, 2'b11);
    wr(2'd1, 64'h1111_1111_CCCC_0003, 2'b10);
    chk("R5 lower-only write", {countHi, countLo}, 64'hAAAA_0001_CCCC_0003);
    wr(2'd1, 64'hDDDD_0004_2222_2222, 2'b01);
    chk("R5 upper-only write", {countHi, countLo}, 64'hDDDD_0004_CCCC_0003);

    // R6 write beats increment in the same cycle
    wr(2'd0, SEL35 | 64'h1, 2'b00);
    ctxMode = 2'd0; evtStrobe = 16'h0028;
    wr(2'd1, 64'h0000_1234_0000_0000, 2'b01);
    evtStrobe = '0;
    chk("R6 write wins counter0", {32'b0, countHi}, 64'h1234);
    chk("R6 counter1 counted", {32'b0, countLo}, 64'hCCCC_0004);

    // R10 / R7 preload 2^32-3 on counter0, interrupts off
    wr(2'd1, 64'hFFFF_FFFD_0000_0000, 2'b01);
    pulse(2'd0, 16'h0008);
    pulse(2'd0, 16'h0008);
    chk("R10 no flag before N-th event", {62'b0, ovfStatus}, 64'd0);
    pulse(2'd0, 16'h0008);
    chk("R7 wrap flag counter0", {62'b0, ovfStatus}, 64'b01);
    chk("R7 counter0 wrapped to 0", {32'b0, countHi}, 64'd0);
    pulse(2'd0, 16'h0008);
    chk("R7 counts on from 0", {32'b0, countHi}, 64'd1);
    chk("R9 irq low while disabled", {63'b0, irq}, 64'd0);

    // R4 idle counter1 still wraps
    wr(2'd1, 64'hFFFF_FFFF, 2'b10);
    pulse(2'd0, 16'h0020);
    rd(2'd2, v); chk("R4 idle counter1 flags", v, 64'b11);

    // R9 enabling interrupts raises irq
    wr(2'd0, SEL35 | 64'h9, 2'b00);
    chk("R9 irq raised", {63'b0, irq}, 64'd1);

    // R8 sticky and write-one-to-clear
    repeat (3) @(negedge clk);
    chk("R8 sticky", {62'b0, ovfStatus}, 64'b11);
    wr(2'd2, 64'h1, 2'b00);
    chk("R8 clear bit0 only", {62'b0, ovfStatus}, 64'b10);
    chk("R9 irq still up", {63'b0, irq}, 64'd1);
    wr(2'd2, 64'h2, 2'b00);
    chk("R8 clear bit1", {62'b0, ovfStatus}, 64'b00);
    chk("R9 irq drops", {63'b0, irq}, 64'd0);

    // R8 wrap and clear in the same cycle: set wins
    wr(2'd1, 64'hFFFF_FFFF_0000_0000, 2'b01);
    ctxMode = 2'd0; evtStrobe = 16'h0008;
    wr(2'd2, 64'h1, 2'b00);
    evtStrobe = '0;
    chk("R8 set beats clear", {62'b0, ovfStatus}, 64'b01);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule